// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Arbiter

This block decides which of five interrupt requests a small processor core services next, and when. The sources are two external request pins (active low), two timer overflow flags and one combined serial-port flag. Software supplies a per-source enable mask, a master enable and a per-source priority mask with two levels. The arbiter produces a one-cycle vector strobe carrying the entry address of the chosen handler. It also reports which priority levels currently have a handler in progress.

Requests are captured on a machine-cycle strobe and acted on at the next strobe. A vector is only issued at the last machine cycle of an instruction. It is held back while the core runs a return-from-interrupt or writes the enable or priority masks. A high-level request may interrupt a low-level handler, but never the reverse. Each external pin can be set to level mode (low means request) or to falling-edge mode. In edge mode the edge is latched and the latch is cleared when that pin's vector is issued. The core pulses a return strobe when a handler ends, which closes the innermost active level.

Top module: `irq_arbiter`

## Requirements
- R1: After reset no vector strobe is active and both in-service bits read 0.
- R2: While the master enable is 0 no vector is issued, whatever the flags.
- R3: A source whose own enable bit is 0 never receives a vector.
- R4: The source index is 0 ext pin 0, 1 timer 0, 2 ext pin 1, 3 timer 1, 4 serial, and the vector address is 0x03 + 8 × index (0x03, 0x0B, 0x13, 0x1B, 0x23).
- R5: Among eligible requests of the same level, the lowest index wins.
- R6: When eligible requests of both levels are pending, a high-level one (priority mask bit 1) wins.
- R7: A high-level request preempts a running low-level handler. A low-level request waits while any handler runs. Nothing is issued while a high-level handler runs.
- R8: A request present at machine-cycle strobe k is sampled there, and its vector strobe is registered on strobe k+1 at the earliest. The strobe lasts one clock.
- R9: In edge mode (mode bit 1) a high-to-low change of the pin between two strobes latches one request. Issuing that pin's vector clears the latch, so a pin held low gives exactly one vector.
- R10: In level mode (mode bit 0) the pin requests whenever it is low at a strobe.
- R11: No vector is issued at a strobe where the last-cycle-of-instruction input is 0.
- R12: No vector is issued at a strobe where the blocking-instruction input is 1.
- R13: A return strobe clears the high in-service bit if it is set, and otherwise the low one. In-service bit 1 is the high level and bit 0 is the low level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mc_tick | input | 1 | One-clock strobe at the end of each machine cycle |
| ext_n | input | 2 | External request pins, active low |
| ext_edge | input | 2 | Per-pin mode: 1 falling edge, 0 level |
| tmr_ovf | input | 2 | Timer 0 / timer 1 overflow flags |
| ser_flag | input | 1 | Combined serial receive/transmit flag |
| glob_en | input | 1 | Master interrupt enable |
| src_en | input | 5 | Per-source enable, bit = source index |
| src_hi | input | 5 | Per-source priority, 1 = high level |
| instr_last | input | 1 | Current machine cycle is the instruction's last |
| blk_instr | input | 1 | Instruction in progress is a return or writes the enable/priority masks |
| reti_pulse | input | 1 | Return-from-interrupt strobe |
| vec_valid | output | 1 | One-clock vector strobe |
| vec_addr | output | 8 | Handler entry address, valid with vec_valid |
| in_service | output | 2 | In-service levels: bit 1 high, bit 0 low |

## Verification
The assertions assume that mc_tick never stays high on two clocks in a row, and that reti_pulse arrives only on a strobe where blk_instr and instr_last are also high, as happens when the return instruction finishes. The stimulus raises mc_tick once every four clocks and changes inputs only on the idle clocks between strobes. In the random phase it asserts the return strobe only together with the blocking input. Flags, pins, modes, masks and the instruction inputs are otherwise drawn freely, so preemption, blocking and edge latching all occur.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int NSRC     = 5;
  localparam int SRC_W    = $clog2(NSRC);
  localparam int VEC_W    = 8;
  localparam int VEC_BASE = 3;
  localparam int VEC_STEP = 8;
  localparam int NEXT     = 2;

  typedef enum logic {LVL_LO = 1'b0, LVL_HI = 1'b1} lvl_e;

  // entry address of a source's handler
  function automatic logic [VEC_W-1:0] vector_of(input logic [SRC_W-1:0] idx);
    return VEC_W'(VEC_BASE + int'(idx) * VEC_STEP);
  endfunction

  // lowest set bit index (polling order)
  function automatic logic [SRC_W-1:0] first_of(input logic [NSRC-1:0] v);
    logic [SRC_W-1:0] r;
    r = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (v[i]) r = SRC_W'(i);
    return r;
  endfunction
endpackage

// File: rtl/irq_pin_detect.sv
module irq_pin_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pin_n,
  input  logic edge_mode,
  input  logic clr,
  output logic req
);
  logic pin_q;
  logic flag;
  logic fall;

  assign fall = pin_q & ~pin_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_q <= 1'b1;
      flag  <= 1'b0;
    end else if (tick) begin
      pin_q <= pin_n;
      if (fall && edge_mode) flag <= 1'b1;
      else if (clr)          flag <= 1'b0;
    end
  end

  assign req = edge_mode ? (flag | fall) : ~pin_n;

  p_flag_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && fall && edge_mode) |=> flag);
  p_flag_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && clr && !(fall && edge_mode)) |=> !flag);
endmodule

// File: rtl/irq_poll.sv
module irq_poll
  import irq_arb_pkg::*;
(
  input  logic [NSRC-1:0]  smp,
  input  logic [NSRC-1:0]  en,
  input  logic             glob,
  input  logic [NSRC-1:0]  prio,
  input  logic             ins_hi,
  input  logic             ins_lo,
  output logic             pick_valid,
  output logic [SRC_W-1:0] pick_idx,
  output lvl_e             pick_lvl
);
  logic [NSRC-1:0] elig;
  logic [NSRC-1:0] hi_c;
  logic [NSRC-1:0] lo_c;

  assign elig = smp & en & {NSRC{glob}};
  assign hi_c = elig & prio;
  assign lo_c = elig & ~prio;

  always_comb begin
    pick_valid = 1'b0;
    pick_idx   = '0;
    pick_lvl   = LVL_LO;
    if (|hi_c) begin
      if (!ins_hi) begin
        pick_valid = 1'b1;
        pick_idx   = first_of(hi_c);
        pick_lvl   = LVL_HI;
      end
    end else if (|lo_c && !ins_hi && !ins_lo) begin
      pick_valid = 1'b1;
      pick_idx   = first_of(lo_c);
    end
  end
endmodule

// File: rtl/irq_service.sv
module irq_service
  import irq_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take,
  input  lvl_e       take_lvl,
  input  logic       reti,
  output logic [1:0] ins
);
  logic [1:0] ins_q;
  logic [1:0] ins_d;

  always_comb begin
    ins_d = ins_q;
    if (reti) begin
      if (ins_d[1]) ins_d[1] = 1'b0;
      else          ins_d[0] = 1'b0;
    end
    if (take) begin
      if (take_lvl == LVL_HI) ins_d[1] = 1'b1;
      else                    ins_d[0] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ins_q <= '0;
    else        ins_q <= ins_d;
  end

  assign ins = ins_q;

  p_lo_no_nest_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && take_lvl == LVL_LO) |-> (ins_q == 2'b00));
  p_hi_no_nest_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && take_lvl == LVL_HI) |-> !ins_q[1]);
  p_reti_hi_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !take && ins_q[1]) |=> (!ins_q[1] && ins_q[0] == $past(ins_q[0])));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_arb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mc_tick,
  input  logic [NEXT-1:0]  ext_n,
  input  logic [NEXT-1:0]  ext_edge,
  input  logic [1:0]       tmr_ovf,
  input  logic             ser_flag,
  input  logic             glob_en,
  input  logic [NSRC-1:0]  src_en,
  input  logic [NSRC-1:0]  src_hi,
  input  logic             instr_last,
  input  logic             blk_instr,
  input  logic             reti_pulse,
  output logic             vec_valid,
  output logic [VEC_W-1:0] vec_addr,
  output logic [1:0]       in_service
);
  logic [NEXT-1:0]  ext_req;
  logic [NSRC-1:0]  raw_req;
  logic [NSRC-1:0]  smp_q;
  logic [NSRC-1:0]  take_mask;
  logic             pick_valid;
  logic [SRC_W-1:0] pick_idx;
  lvl_e             pick_lvl;
  logic             take;
  logic [1:0]       ins;

  // external pins sit at even indices 0 and 2 of the polling order
  for (genvar g = 0; g < NEXT; g++) begin : g_ext
    irq_pin_detect u_pin (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (mc_tick),
      .pin_n     (ext_n[g]),
      .edge_mode (ext_edge[g]),
      .clr       (take_mask[2*g]),
      .req       (ext_req[g])
    );
  end

  assign raw_req = {ser_flag, tmr_ovf[1], ext_req[1], tmr_ovf[0], ext_req[0]};

  irq_poll u_poll (
    .smp        (smp_q),
    .en         (src_en),
    .glob       (glob_en),
    .prio       (src_hi),
    .ins_hi     (ins[1]),
    .ins_lo     (ins[0]),
    .pick_valid (pick_valid),
    .pick_idx   (pick_idx),
    .pick_lvl   (pick_lvl)
  );

  assign take      = mc_tick & instr_last & ~blk_instr & pick_valid;
  assign take_mask = take ? (NSRC'(1) << pick_idx) : '0;

  irq_service u_svc (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .take_lvl (pick_lvl),
    .reti     (reti_pulse),
    .ins      (ins)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smp_q     <= '0;
      vec_valid <= 1'b0;
      vec_addr  <= '0;
    end else begin
      vec_valid <= take;
      if (take) vec_addr <= vector_of(pick_idx);
      if (mc_tick) smp_q <= raw_req & ~take_mask;
    end
  end

  assign in_service = ins;

  p_vec_last_r11: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> $past(mc_tick && instr_last));
  p_vec_unblocked_r12: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> !$past(blk_instr));
  p_take_enabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (glob_en && src_en[pick_idx]));
  p_hi_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && glob_en && |(smp_q & src_en & src_hi)) |-> pick_lvl == LVL_HI);
  p_vec_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |=> !vec_valid);
endmodule

// File: tb/irq_arbiter_tb.sv
module irq_arbiter_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       mc_tick, instr_last, blk_instr, reti_pulse;
  logic [1:0] ext_n, ext_edge, tmr_ovf;
  logic       ser_flag, glob_en;
  logic [4:0] src_en, src_hi;
  logic       vec_valid;
  logic [7:0] vec_addr;
  logic [1:0] in_service;

  int n_chk = 0;
  int n_err = 0;

  // bench-side reference state
  logic [4:0] m_smp;
  logic [1:0] m_flag, m_prev, m_ins;
  logic       m_vv;
  logic [7:0] m_va;

  always #5 clk = ~clk;

  irq_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .ext_n(ext_n),
    .ext_edge(ext_edge), .tmr_ovf(tmr_ovf), .ser_flag(ser_flag),
    .glob_en(glob_en), .src_en(src_en), .src_hi(src_hi),
    .instr_last(instr_last), .blk_instr(blk_instr), .reti_pulse(reti_pulse),
    .vec_valid(vec_valid), .vec_addr(vec_addr), .in_service(in_service)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int addr_of(input int idx);
    return 3 + idx * 8;
  endfunction

  // behaviour at one strobe, from the requirements
  task automatic model_step();
    logic [4:0] elig, hc, lc, raw, mask;
    logic [1:0] f;
    int idx;
    bit tk, lvl;
    elig = m_smp & src_en & {5{glob_en}};
    hc = elig & src_hi;
    lc = elig & ~src_hi;
    tk = 0; idx = 0; lvl = 0;
    if (hc != 0) begin
      if (!m_ins[1]) begin
        tk = 1; lvl = 1;
        for (int i = 4; i >= 0; i--) if (hc[i]) idx = i;
      end
    end else if (lc != 0 && m_ins == 2'b00) begin
      tk = 1;
      for (int i = 4; i >= 0; i--) if (lc[i]) idx = i;
    end
    tk = tk && instr_last && !blk_instr;
    if (reti_pulse) begin
      if (m_ins[1]) m_ins[1] = 1'b0;
      else          m_ins[0] = 1'b0;
    end
    if (tk) m_ins[lvl] = 1'b1;
    f = m_prev & ~ext_n;
    raw[0] = ext_edge[0] ? (m_flag[0] | f[0]) : !ext_n[0];
    raw[2] = ext_edge[1] ? (m_flag[1] | f[1]) : !ext_n[1];
    raw[1] = tmr_ovf[0];
    raw[3] = tmr_ovf[1];
    raw[4] = ser_flag;
    mask = tk ? (5'b00001 << idx) : 5'b0;
    for (int g = 0; g < 2; g++) begin
      if (f[g] && ext_edge[g]) m_flag[g] = 1'b1;
      else if (mask[2*g])      m_flag[g] = 1'b0;
    end
    m_smp  = raw & ~mask;
    m_prev = ext_n;
    m_vv   = tk;
    m_va   = 8'(addr_of(idx));
  endtask

  task automatic tick(input bit last, input bit blk, input bit reti);
    repeat (3) @(negedge clk);
    instr_last = last; blk_instr = blk; reti_pulse = reti; mc_tick = 1'b1;
    model_step();
    @(negedge clk);
    mc_tick = 1'b0; instr_last = 1'b0; blk_instr = 1'b0; reti_pulse = 1'b0;
    check("R8 model valid", int'(vec_valid), int'(m_vv));
    if (m_vv) check("R4 model addr", int'(vec_addr), int'(m_va));
    check("R13 model in_service", int'(in_service), int'(m_ins));
  endtask

  task automatic expect_out(input string tag, input bit v, input int a, input int ins);
    check({tag, " valid"}, int'(vec_valid), int'(v));
    if (v) check({tag, " addr"}, int'(vec_addr), a);
    check({tag, " in_service"}, int'(in_service), ins);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; mc_tick = 0; instr_last = 0; blk_instr = 0; reti_pulse = 0;
    ext_n = 2'b11; ext_edge = 2'b00; tmr_ovf = 2'b00; ser_flag = 0;
    glob_en = 1; src_en = 5'h1f; src_hi = 5'h00;
    m_smp = 0; m_flag = 0; m_prev = 2'b11; m_ins = 0; m_vv = 0; m_va = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_out("R1 reset", 0, 0, 0);

    // R2 master enable, then R4 vector of timer 0
    glob_en = 0; tmr_ovf[0] = 1;
    tick(1, 0, 0); tick(1, 0, 0);
    expect_out("R2 master off", 0, 0, 0);
    glob_en = 1;
    tick(1, 0, 0);
    expect_out("R4 timer0 vector", 1, 'h0B, 1);
    tmr_ovf[0] = 0;
    tick(1, 1, 1);
    expect_out("R13 return low", 0, 0, 0);

    // R8 / R11 / R12 with serial
    ser_flag = 1;
    tick(1, 0, 0); expect_out("R8 sampled only", 0, 0, 0);
    tick(0, 0, 0); expect_out("R11 not last", 0, 0, 0);
    tick(1, 1, 0); expect_out("R12 blocked", 0, 0, 0);
    tick(1, 0, 0); expect_out("R8 serial vector", 1, 'h23, 1);
    ser_flag = 0;
    tick(1, 1, 1);

    // R5 same level order, R7 preemption
    tmr_ovf[1] = 1; ser_flag = 1;
    tick(0, 0, 0);
    tick(1, 0, 0); expect_out("R5 timer1 before serial", 1, 'h1B, 1);
    src_hi = 5'b10000;
    tick(1, 0, 0); expect_out("R7 high preempts low", 1, 'h23, 3);
    ser_flag = 0;
    tick(1, 1, 1); expect_out("R13 return high first", 0, 0, 1);
    tick(1, 0, 0); expect_out("R7 low waits for low", 0, 0, 1);
    tmr_ovf[1] = 0;
    tick(1, 1, 1);
    src_hi = 0;

    // R6 high beats low, R10 level pin, R7 high blocks all
    src_hi = 5'b00100; ext_n[1] = 0; tmr_ovf[0] = 1;
    tick(0, 0, 0);
    tick(1, 0, 0); expect_out("R6 R10 ext1 high", 1, 'h13, 2);
    tick(1, 0, 0); expect_out("R7 high blocks", 0, 0, 2);
    ext_n[1] = 1;
    tick(1, 1, 1);
    tick(1, 0, 0); expect_out("R6 low after return", 1, 'h0B, 1);
    tmr_ovf[0] = 0;
    tick(1, 1, 1);
    src_hi = 0;

    // R3 per-source enable
    src_en = 5'b11101; tmr_ovf[0] = 1;
    tick(1, 0, 0); tick(1, 0, 0);
    expect_out("R3 source disabled", 0, 0, 0);
    tmr_ovf[0] = 0; src_en = 5'h1f;
    tick(1, 1, 0);

    // R9 edge mode, then R10 level mode on ext0
    ext_edge[0] = 1;
    tick(0, 0, 0);
    ext_n[0] = 0;
    tick(0, 0, 0);
    tick(1, 0, 0); expect_out("R9 edge vector", 1, 'h03, 1);
    tick(1, 1, 1);
    tick(1, 0, 0); expect_out("R9 one per edge", 0, 0, 0);
    ext_edge[0] = 0;
    tick(1, 0, 0);
    tick(1, 0, 0); expect_out("R10 level ext0", 1, 'h03, 1);
    ext_n[0] = 1;
    tick(1, 1, 1);

    // random phase against the reference model
    for (int n = 0; n < 500; n++) begin
      bit l, b, r;
      ext_n    = 2'($urandom % 4);
      if ($urandom % 8 == 0) ext_edge = 2'($urandom % 4);
      tmr_ovf  = {($urandom % 4 == 0), ($urandom % 4 == 0)};
      ser_flag = ($urandom % 4 == 0);
      src_en   = 5'($urandom) | 5'($urandom);
      glob_en  = ($urandom % 10 != 0);
      src_hi   = 5'($urandom);
      if ($urandom % 4 == 0) begin
        l = 1; b = 1; r = 1;
      end else begin
        l = ($urandom % 10 < 7); b = ($urandom % 10 == 0); r = 0;
      end
      tick(l, b, r);
    end

    summary();
    $finish;
  end
endmodule